// File: doc/BRIEF.md
# Processor Bus Command Controller

This block sits between a pipelined processor and its memory and I/O buses. It watches a two-bit encoded bus status and a memory/IO select, and turns them into the timed control strobes that the surrounding logic needs. Those strobes are an address latch enable, a data transceiver enable, a transceiver direction signal, four separate read/write command strobes (memory read, memory write, I/O read, I/O write) and an interrupt-acknowledge strobe.

Each clock of `clk` is one processor clock phase, so one bus state takes two clocks. A bus cycle is a send-status state followed by a perform-command state. The status is sampled on the edge in the middle of the send-status state, which is the only clock in which the controller is free. The latch enable pulses in the second half of that state, and the command strobe covers the whole perform-command state. An active-low `ready_n` is sampled on the edge that ends the perform-command state. If it is high there, the perform-command state repeats as a wait state. Because the processor may drive the next cycle's status while the current command is still running, status is ignored outside the free slot.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: After reset, and in every free clock, all command strobes, `ale` and `den` are 0 and `dt_r` is 1 (transmit).
- R2: Status decoding: `bus_stat`=2'b10 is a write and 2'b01 is a read. With `mem_sel`=1 the target is memory, and with 0 it is I/O. 2'b00 with `mem_sel`=0 is an interrupt acknowledge.
- R3: Status is sampled only on an edge that ends a free clock. A valid code makes `ale` 1 for exactly the next clock, and `ale` is never 1 together with a command strobe.
- R4: For a write, `den` is 1 from the `ale` clock through the last command clock. For a read or interrupt acknowledge, `den` is 1 only in the command clocks.
- R5: `dt_r` is 0 (receive) from the `ale` clock through the last command clock of a read or interrupt-acknowledge cycle, and is 1 otherwise.
- R6: The command strobe selected by R2 is 1 for the two clocks after the `ale` clock. At most one command strobe is 1 at any time.
- R7: `ready_n` is sampled only on the edge that ends the second command clock. A 1 there adds two more command clocks; a 0 ends the cycle and all strobes return to the R1 state.
- R8: Status driven during command or wait clocks has no effect. After the last command clock there is one free clock, and `ale` can rise no earlier than the clock after it.
- R9: Codes 2'b11, and 2'b00 with `mem_sel`=1, start no cycle: every output stays in its R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one edge per processor clock phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stat | input | 2 | Encoded bus status from the processor |
| mem_sel | input | 1 | 1 selects memory, 0 selects I/O |
| ready_n | input | 1 | Active-low cycle-complete input |
| ale | output | 1 | Address latch enable pulse |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Transceiver direction, 1 transmit, 0 receive |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| int_ack | output | 1 | Interrupt acknowledge strobe |

## Verification
Two functions can act in the same clock: `ready_n` ending the current command, and a pipelined status for the next cycle that is already on the bus. The bench drives the next status from the first command clock onward, through every wait state, while `ready_n` decides when the current command ends. It also drives `ready_n` low in the first command clock to show that this sample is ignored. In each clock it compares the full output vector against values computed from the status code and the wait count. The command must run its full length, no `ale` may appear during the command or wait clocks, and the clock after the last command must be free.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] ST_INTA  = 2'b00;
  localparam logic [STAT_W-1:0] ST_READ  = 2'b01;
  localparam logic [STAT_W-1:0] ST_WRITE = 2'b10;
  localparam logic [STAT_W-1:0] ST_IDLE  = 2'b11;

  typedef enum logic [2:0] {
    K_NONE, K_MRD, K_MWR, K_IORD, K_IOWR, K_INTA
  } kind_t;

  typedef enum logic [1:0] {
    PH_FREE, PH_LATCH, PH_CMD1, PH_CMD2
  } phase_t;

  function automatic kind_t decode_kind(input logic [STAT_W-1:0] st, input logic mem);
    kind_t k;
    k = K_NONE;
    case (st)
      ST_WRITE: k = mem ? K_MWR : K_IOWR;
      ST_READ:  k = mem ? K_MRD : K_IORD;
      ST_INTA:  k = mem ? K_NONE : K_INTA;
      default:  k = K_NONE;
    endcase
    return k;
  endfunction

  function automatic logic is_receive(input kind_t k);
    return (k == K_MRD) || (k == K_IORD) || (k == K_INTA);
  endfunction
endpackage

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
  import bus_cmd_pkg::*;
(
  input  logic [STAT_W-1:0] bus_stat,
  input  logic              mem_sel,
  output kind_t             kind,
  output logic              req_valid
);
  always_comb begin
    kind      = decode_kind(bus_stat, mem_sel);
    req_valid = (kind != K_NONE);
  end
endmodule

// File: rtl/bus_cmd_seq.sv
module bus_cmd_seq
  import bus_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  kind_t  kind_in,
  input  logic   ready_n,
  output phase_t phase,
  output kind_t  kind_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FREE;
      kind_q <= K_NONE;
    end else begin
      case (phase)
        PH_FREE: begin
          if (kind_in != K_NONE) begin
            phase  <= PH_LATCH;
            kind_q <= kind_in;
          end
        end
        PH_LATCH: phase <= PH_CMD1;
        PH_CMD1:  phase <= PH_CMD2;
        PH_CMD2: begin
          if (ready_n) begin
            phase <= PH_CMD1;
          end else begin
            phase  <= PH_FREE;
            kind_q <= K_NONE;
          end
        end
        default: phase <= PH_FREE;
      endcase
    end
  end
endmodule

// File: rtl/bus_cmd_strobes.sv
module bus_cmd_strobes
  import bus_cmd_pkg::*;
(
  input  phase_t phase,
  input  kind_t  kind_q,
  output logic   ale,
  output logic   den,
  output logic   dt_r,
  output logic   mem_rd,
  output logic   mem_wr,
  output logic   io_rd,
  output logic   io_wr,
  output logic   int_ack
);
  logic in_cmd;
  logic rx;

  always_comb begin
    in_cmd  = (phase == PH_CMD1) || (phase == PH_CMD2);
    rx      = is_receive(kind_q);
    ale     = (phase == PH_LATCH);
    den     = in_cmd || ((phase == PH_LATCH) && !rx);
    dt_r    = !(rx && (phase != PH_FREE));
    mem_rd  = in_cmd && (kind_q == K_MRD);
    mem_wr  = in_cmd && (kind_q == K_MWR);
    io_rd   = in_cmd && (kind_q == K_IORD);
    io_wr   = in_cmd && (kind_q == K_IOWR);
    int_ack = in_cmd && (kind_q == K_INTA);
  end
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] bus_stat,
  input  logic              mem_sel,
  input  logic              ready_n,
  output logic              ale,
  output logic              den,
  output logic              dt_r,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              int_ack
);
  kind_t  dec_kind;
  logic   req_valid;
  phase_t phase;
  kind_t  kind_q;

  // named events for the checker
  logic ev_free;
  logic ev_ready_slot;
  assign ev_free       = (phase == PH_FREE);
  assign ev_ready_slot = (phase == PH_CMD2);

  bus_cmd_decode u_decode (
    .bus_stat (bus_stat),
    .mem_sel  (mem_sel),
    .kind     (dec_kind),
    .req_valid(req_valid)
  );

  bus_cmd_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind_in(dec_kind),
    .ready_n(ready_n),
    .phase  (phase),
    .kind_q (kind_q)
  );

  bus_cmd_strobes u_strobes (
    .phase  (phase),
    .kind_q (kind_q),
    .ale    (ale),
    .den    (den),
    .dt_r   (dt_r),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .int_ack(int_ack)
  );
endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ready_n,
  input logic req_valid,
  input logic ev_free,
  input logic ev_ready_slot,
  input logic ale,
  input logic den,
  input logic dt_r,
  input logic mem_rd,
  input logic mem_wr,
  input logic io_rd,
  input logic io_wr,
  input logic int_ack
);
  logic any_cmd;
  assign any_cmd = mem_rd | mem_wr | io_rd | io_wr | int_ack;

  // R3
  ale_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_free && req_valid) |=> ale);
  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  // R3
  ale_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && any_cmd));
  // R6
  ale_then_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> any_cmd);
  // R6
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));
  // R7
  wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready_slot && ready_n) |=> (any_cmd && $stable({mem_rd, mem_wr, io_rd, io_wr, int_ack})));
  // R7
  ready_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready_slot && !ready_n) |=> (!any_cmd && !den && !ale));
  // R5
  write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || io_wr) |-> (dt_r && den));
  // R5
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || io_rd || int_ack) |-> (!dt_r && den));
endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready_n      (ready_n),
  .req_valid    (req_valid),
  .ev_free      (ev_free),
  .ev_ready_slot(ev_ready_slot),
  .ale          (ale),
  .den          (den),
  .dt_r         (dt_r),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .int_ack      (int_ack)
);

// File: tb/bus_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module bus_cmd_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_stat = 2'b11;
  logic       mem_sel = 1'b0;
  logic       ready_n = 1'b1;
  logic       ale, den, dt_r, mem_rd, mem_wr, io_rd, io_wr, int_ack;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_cmd_ctrl u_bus_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .mem_sel(mem_sel),
    .ready_n(ready_n), .ale(ale), .den(den), .dt_r(dt_r),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .int_ack(int_ack)
  );

  // vector order: ale den dt_r mem_rd mem_wr io_rd io_wr int_ack
  // where: 0 free clock, 1 latch clock, 2 command clock
  function automatic logic [7:0] expect_vec(int where, logic [1:0] st, logic m);
    logic wr, rd, ia, rx;
    wr = (st == 2'b10);
    rd = (st == 2'b01);
    ia = (st == 2'b00) && !m;
    rx = rd | ia;
    if (where == 0) return 8'b0010_0000;
    if (where == 1) return {1'b1, wr, !rx, 5'b0};
    return {1'b0, 1'b1, !rx, rd & m, wr & m, rd & !m, wr & !m, ia};
  endfunction

  task automatic check(string req, logic [7:0] exp);
    logic [7:0] got;
    got = {ale, den, dt_r, mem_rd, mem_wr, io_rd, io_wr, int_ack};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Entered at a negedge in a free clock.
  task automatic bus_cycle(logic [1:0] st, logic m, int waits, logic [1:0] nxt);
    bus_stat = st; mem_sel = m; ready_n = 1'b1;
    step();
    check("R3 R4 R5 latch clock", expect_vec(1, st, m));
    bus_stat = 2'b11;
    for (int w = 0; w <= waits; w++) begin
      step();
      check("R6 R2 command clock 1", expect_vec(2, st, m));
      bus_stat = nxt;             // R8 pipelined status during command
      ready_n  = 1'b0;            // R7 ignored in first command clock
      step();
      check("R6 R7 command clock 2", expect_vec(2, st, m));
      ready_n = (w == waits) ? 1'b0 : 1'b1;
    end
    step();
    check("R8 R7 free after command", expect_vec(0, st, m));
    ready_n = 1'b1;
  endtask

  task automatic no_cycle(logic [1:0] st, logic m);
    bus_stat = st; mem_sel = m;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R9 R1 no cycle", 8'b0010_0000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'b0010_0000);
    rst_n = 1'b1;
    step();
    check("R1 after reset", 8'b0010_0000);
    for (int s = 0; s < 4; s++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int w = 0; w < 3; w++) begin
          logic [1:0] st;
          logic m;
          st = s[1:0];
          m  = mi[0];
          if (st == 2'b11 || (st == 2'b00 && m)) no_cycle(st, m);
          else bus_cycle(st, m, w, 2'b10 ^ st ^ {1'b0, m});
        end
      end
    end
    // R8: back-to-back with the same pipelined code held into the free clock
    bus_cycle(2'b10, 1'b1, 0, 2'b01);
    bus_cycle(2'b01, 1'b1, 1, 2'b00);
    bus_cycle(2'b00, 1'b0, 0, 2'b11);
    no_cycle(2'b11, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule